// File: doc/BRIEF.md
# Sparse Ring-Product Encryption Sequencer

This block computes one lattice ciphertext, e = h*r + m (mod q), over the cyclic ring of degree N with q a power of two. The public key h is a fixed table inside the block. The random polynomial r and the binary message m arrive serially, one bit per clock. Because r is binary and has only a few ones, the block does not multiply. During a load phase it records where the ones of r sit. For each output coefficient it then adds up the key entries those positions select, adds one message bit, and presents the result with a one-cycle strobe.

A caller pulses `enc` while the block is idle. It then shifts in the N coefficients of r, lowest index first, on the following N clocks. After that it supplies each message bit while the matching coefficient is being finished. The ciphertext comes out in index order, one coefficient every DR+1 cycles.

Top module: `spenc_top`

## Requirements
- R1: After reset `coefValid`, `coefOut` and `coefIdx` are all 0, and the block is idle, so a pulse on `enc` is accepted.
- R2: When `enc` is sampled high while idle, the next N clock edges each sample `rIn` as one coefficient of r, in index order from 0 to N-1.
- R3: Let p be each recorded position of a one in r. Coefficient k equals the sum of h[(k - p) mod N] over all recorded positions, plus m[k]. The key table is h[i] = (i*KEY_MUL + KEY_ADD) mod 2^QW, with defaults KEY_MUL=37, KEY_ADD=11, QW=6, N=107 and DR=5.
- R4: All sums are reduced mod 2^QW (64 by default) by wrapping.
- R5: The message bit m[k] is taken from `mIn` at the last of the DR+1 clock edges that produce coefficient k.
- R6: Each coefficient is presented with `coefValid` high for exactly one cycle. `coefIdx` runs from 0 to N-1 in order, and each encryption gives exactly N strobes.
- R7: Counting from the edge that samples `enc`, the strobe for coefficient k is visible after edge N + (k+1)*(DR+1). The last strobe is visible after edge N + N*(DR+1), which is 749 by default.
- R8: `enc` is ignored while the block is loading or computing, and the results are unchanged by it.
- R9: If r holds more than DR ones, only the first DR positions (the lowest indices) are used.
- R10: If r holds fewer than DR ones, the unused slots add nothing. With no ones at all, each coefficient equals its message bit.
- R11: After the last coefficient the block returns to idle and accepts the next `enc` immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enc | input | 1 | Start request, honoured only when idle |
| rIn | input | 1 | Serial coefficient of r during load |
| mIn | input | 1 | Serial message bit, used during each add cycle |
| coefOut | output | QW | Cipher coefficient value |
| coefIdx | output | $clog2(N) | Index of the presented coefficient |
| coefValid | output | 1 | One-cycle strobe marking a new coefficient |

## Verification
The key timing points are measured from the edge that samples `enc`:
- The load window ends after N edges.
- The first strobe is visible after edge N+DR+1.
- Each later strobe follows the previous one by DR+1 edges.
- The final strobe is visible after edge 749 by default.

The bench drives every input on the falling edge. It records the cycle number of each strobe on the falling edge that follows the producing rising edge, and compares that number with the offsets above. Message bits are held stable across all DR+1 edges of their coefficient, so the add edge always sees the intended bit. After each run the bench waits past the last due strobe to confirm that no extra strobe appears.

// File: rtl/spenc_pkg.sv
package spenc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_MUL  = 2'd2,
    ST_ADD  = 2'd3
  } encState_t;

  typedef struct packed {
    logic clrAll;
    logic loadStep;
    logic mulStep;
    logic addStep;
  } encStrobe_t;
endpackage

// File: rtl/spenc_ctrl.sv
module spenc_ctrl
  import spenc_pkg::*;
#(
  parameter int N  = 107,
  parameter int DR = 5,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(DR + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enc,
  output encStrobe_t      strobe,
  output logic [IW-1:0]   loadIdx,
  output logic [CW-1:0]   termSel,
  output logic [IW-1:0]   coefSel,
  output encState_t       stateOut
);
  encState_t state;

  always_comb begin
    strobe.clrAll   = (state == ST_IDLE) && enc;
    strobe.loadStep = (state == ST_LOAD);
    strobe.mulStep  = (state == ST_MUL);
    strobe.addStep  = (state == ST_ADD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      loadIdx <= '0;
      termSel <= '0;
      coefSel <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (enc) begin
            state   <= ST_LOAD;
            loadIdx <= '0;
          end
        end
        ST_LOAD: begin
          if (loadIdx == IW'(N - 1)) begin
            state   <= ST_MUL;
            termSel <= '0;
            coefSel <= '0;
          end else begin
            loadIdx <= loadIdx + 1'b1;
          end
        end
        ST_MUL: begin
          if (termSel == CW'(DR - 1)) begin
            state <= ST_ADD;
          end else begin
            termSel <= termSel + 1'b1;
          end
        end
        ST_ADD: begin
          termSel <= '0;
          if (coefSel == IW'(N - 1)) begin
            state <= ST_IDLE;
          end else begin
            coefSel <= coefSel + 1'b1;
            state   <= ST_MUL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign stateOut = state;
endmodule

// File: rtl/spenc_datapath.sv
module spenc_datapath
  import spenc_pkg::*;
#(
  parameter int N       = 107,
  parameter int QW      = 6,
  parameter int DR      = 5,
  parameter int KEY_MUL = 37,
  parameter int KEY_ADD = 11,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(DR + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  encStrobe_t      strobe,
  input  logic [IW-1:0]   loadIdx,
  input  logic [CW-1:0]   termSel,
  input  logic [IW-1:0]   coefSel,
  input  logic            rIn,
  input  logic            mIn,
  output logic [QW-1:0]   coefOut,
  output logic [IW-1:0]   coefIdx,
  output logic            coefValid
);
  logic [IW-1:0] slotPos [DR];
  logic [CW-1:0] onesSeen;
  logic [QW-1:0] acc;
  logic [IW:0]   kExt, pExt, diffExt;
  logic [IW-1:0] romAddr;
  logic [QW-1:0] romVal;
  logic          termLive;

  function automatic logic [QW-1:0] keyRom(input logic [IW-1:0] a);
    int v;
    v = int'({1'b0, a}) * KEY_MUL + KEY_ADD;
    return v[QW-1:0];
  endfunction

  // One storage slot per expected one of r
  for (genvar g = 0; g < DR; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotPos[g] <= '0;
      end else if (strobe.loadStep && rIn && (onesSeen == CW'(g))) begin
        slotPos[g] <= loadIdx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll) begin
      onesSeen <= '0;
    end else if (strobe.loadStep && rIn && (onesSeen < CW'(DR))) begin
      onesSeen <= onesSeen + 1'b1;
    end
  end

  // Rotated key address: (k - p) mod N
  always_comb begin
    kExt     = {1'b0, coefSel};
    pExt     = {1'b0, slotPos[termSel]};
    diffExt  = (kExt >= pExt) ? (kExt - pExt) : (kExt + (IW + 1)'(N) - pExt);
    romAddr  = diffExt[IW-1:0];
    romVal   = keyRom(romAddr);
    termLive = (termSel < onesSeen);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll) begin
      acc <= '0;
    end else if (strobe.mulStep && termLive) begin
      acc <= acc + romVal;
    end else if (strobe.addStep) begin
      acc <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefOut   <= '0;
      coefIdx   <= '0;
      coefValid <= 1'b0;
    end else begin
      coefValid <= strobe.addStep;
      if (strobe.addStep) begin
        coefOut <= acc + QW'(mIn);
        coefIdx <= coefSel;
      end
    end
  end
endmodule

// File: rtl/spenc_top.sv
module spenc_top
  import spenc_pkg::*;
#(
  parameter int N       = 107,
  parameter int QW      = 6,
  parameter int DR      = 5,
  parameter int KEY_MUL = 37,
  parameter int KEY_ADD = 11,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(DR + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enc,
  input  logic          rIn,
  input  logic          mIn,
  output logic [QW-1:0] coefOut,
  output logic [IW-1:0] coefIdx,
  output logic          coefValid
);
  encStrobe_t    strobe;
  logic [IW-1:0] loadIdx;
  logic [CW-1:0] termSel;
  logic [IW-1:0] coefSel;
  encState_t     ctrlState;

  spenc_ctrl #(.N(N), .DR(DR)) u_ctrl (
    .clk(clk), .rstN(rstN), .enc(enc), .strobe(strobe),
    .loadIdx(loadIdx), .termSel(termSel), .coefSel(coefSel),
    .stateOut(ctrlState)
  );

  spenc_datapath #(.N(N), .QW(QW), .DR(DR), .KEY_MUL(KEY_MUL), .KEY_ADD(KEY_ADD)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadIdx(loadIdx),
    .termSel(termSel), .coefSel(coefSel), .rIn(rIn), .mIn(mIn),
    .coefOut(coefOut), .coefIdx(coefIdx), .coefValid(coefValid)
  );
endmodule

// File: rtl/spenc_checker.sv
module spenc_checker
  import spenc_pkg::*;
#(
  parameter int N  = 107,
  parameter int DR = 5,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rstN,
  input encState_t     state,
  input logic          coefValid,
  input logic [IW-1:0] coefIdx
);
  logic [15:0]   loadRun;
  logic [15:0]   mulRun;
  logic [IW-1:0] expIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadRun <= '0;
      mulRun  <= '0;
      expIdx  <= '0;
    end else begin
      loadRun <= (state == ST_LOAD) ? loadRun + 1'b1 : '0;
      mulRun  <= (state == ST_MUL)  ? mulRun + 1'b1  : '0;
      if (state == ST_LOAD)  expIdx <= '0;
      else if (coefValid)    expIdx <= expIdx + 1'b1;
    end
  end

  // R2: the load window never runs past N cycles
  a_r2_load_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |-> (loadRun < 16'(N)));
  // R2: the load window ends into the multiply phase after exactly N cycles
  a_r2_load_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && loadRun == 16'(N - 1)) |=> (state == ST_MUL));
  // R7: each add cycle follows exactly DR multiply cycles
  a_r7_mul_length: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADD) |-> (mulRun == 16'(DR)));
  // R6: every add cycle raises the strobe on the next cycle
  a_r6_strobe_after_add: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADD) |=> coefValid);
  // R6: the strobe lasts a single cycle
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    coefValid |=> !coefValid);
  // R6: the presented indices run in order
  a_r6_index_order: assert property (@(posedge clk) disable iff (!rstN)
    coefValid |-> (coefIdx == expIdx));
  // R8: a busy block never restarts its load
  a_r8_enc_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MUL || state == ST_ADD) |=> (state != ST_LOAD));
  // R11: the last coefficient leaves the block idle
  a_r11_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (coefValid && coefIdx == IW'(N - 1)) |-> (state == ST_IDLE));
endmodule

bind spenc_top spenc_checker #(.N(N), .DR(DR)) u_chk (
  .clk(clk), .rstN(rstN), .state(ctrlState),
  .coefValid(coefValid), .coefIdx(coefIdx)
);

// File: tb/spenc_top_bench.sv
`timescale 1ns/1ps
module spenc_top_bench;
  localparam int N  = 107;
  localparam int QW = 6;
  localparam int DR = 5;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enc = 1'b0;
  logic          rIn = 1'b0;
  logic          mIn = 1'b0;
  logic [QW-1:0] coefOut;
  logic [IW-1:0] coefIdx;
  logic          coefValid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int startCyc = 0;
  int gotCnt = 0;
  int firstCyc = -1;
  int lastCyc = -1;
  bit monOn = 1'b0;
  bit finished = 1'b0;
  string curTag = "";
  int expCoef [N];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spenc_top u_spenc_top (
    .clk(clk), .rstN(rstN), .enc(enc), .rIn(rIn), .mIn(mIn),
    .coefOut(coefOut), .coefIdx(coefIdx), .coefValid(coefValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int keyVal(input int i);
    return (i * 37 + 11) % 64;
  endfunction

  // Strobe monitor: value (R3 R4 R5), order (R6) and timing (R7)
  always @(negedge clk) begin
    if (coefValid) begin
      if (!monOn) begin
        check(1'b0, "R6 stray strobe", 1, 0);
      end else begin
        check(int'(coefIdx) == gotCnt, {curTag, " R6 index"}, int'(coefIdx), gotCnt);
        if (gotCnt < N)
          check(int'(coefOut) == expCoef[gotCnt], {curTag, " R3 R4 R5 value"},
                int'(coefOut), expCoef[gotCnt]);
        check(cyc - startCyc == N + (gotCnt + 1) * (DR + 1), {curTag, " R7 strobe time"},
              cyc - startCyc, N + (gotCnt + 1) * (DR + 1));
        if (gotCnt == 0) firstCyc = cyc - startCyc;
        lastCyc = cyc - startCyc;
        gotCnt++;
      end
    end
  end

  task automatic runEnc(input logic [N-1:0] rv, input logic [N-1:0] mv,
                        input bit poke, input string tag);
    int pos [DR];
    int nPos = 0;
    for (int i = 0; i < N; i++)
      if (rv[i] && nPos < DR) begin pos[nPos] = i; nPos++; end
    for (int k = 0; k < N; k++) begin
      int s = int'(mv[k]);
      for (int t = 0; t < nPos; t++) s += keyVal((k - pos[t] + N) % N);
      expCoef[k] = s % 64;
    end
    curTag = tag;
    gotCnt = 0;
    firstCyc = -1;
    lastCyc = -1;
    @(negedge clk); enc = 1'b1;
    @(negedge clk); enc = 1'b0; startCyc = cyc; monOn = 1'b1;
    rIn = rv[0];
    for (int i = 1; i < N; i++) begin
      @(negedge clk); rIn = rv[i];
      enc = poke && (i == 50);
    end
    for (int k = 0; k < N; k++) begin
      for (int t = 0; t <= DR; t++) begin
        @(negedge clk); rIn = 1'b0; mIn = mv[k];
        enc = poke && (k == 20 || k == 60) && (t < 3);
      end
    end
    enc = 1'b0;
    repeat (DR + 4) @(negedge clk);
    monOn = 1'b0;
    check(gotCnt == N, {tag, " R6 strobe count"}, gotCnt, N);
    check(firstCyc == N + DR + 1, {tag, " R7 first strobe"}, firstCyc, N + DR + 1);
    check(lastCyc == N + N * (DR + 1), {tag, " R7 last strobe"}, lastCyc, N + N * (DR + 1));
  endtask

  task automatic testReset();
    repeat (3) begin
      @(negedge clk);
      check(coefValid == 1'b0, "R1 reset valid", int'(coefValid), 0);
      check(coefOut == '0, "R1 reset value", int'(coefOut), 0);
      check(coefIdx == '0, "R1 reset index", int'(coefIdx), 0);
    end
  endtask

  task automatic testBasic();
    logic [N-1:0] rv = '0;
    logic [N-1:0] mv = '0;
    rv[0] = 1'b1; rv[3] = 1'b1; rv[50] = 1'b1; rv[100] = 1'b1; rv[106] = 1'b1;
    for (int i = 0; i < N; i++) mv[i] = (i % 3 == 1);
    runEnc(rv, mv, 1'b0, "basic R2");
  endtask

  task automatic testWrap();
    logic [N-1:0] rv = '0;
    logic [N-1:0] mv = '1;
    for (int i = N - DR; i < N; i++) rv[i] = 1'b1;
    runEnc(rv, mv, 1'b0, "wrap R4 R11");
  endtask

  task automatic testExtraOnes();
    logic [N-1:0] rv = '0;
    logic [N-1:0] mv = '0;
    rv[1] = 1'b1; rv[2] = 1'b1; rv[3] = 1'b1; rv[4] = 1'b1; rv[5] = 1'b1;
    rv[60] = 1'b1; rv[90] = 1'b1;
    for (int i = 0; i < N; i++) mv[i] = (i % 2 == 0);
    runEnc(rv, mv, 1'b0, "extra R9");
  endtask

  task automatic testFewOnes();
    logic [N-1:0] rv = '0;
    logic [N-1:0] mv = '0;
    rv[10] = 1'b1; rv[20] = 1'b1;
    runEnc(rv, mv, 1'b0, "few R10");
    rv = '0;
    for (int i = 0; i < N; i++) mv[i] = ((i * 7) % 5 < 2);
    runEnc(rv, mv, 1'b0, "none R10");
  endtask

  task automatic testBusyEnc();
    logic [N-1:0] rv = '0;
    logic [N-1:0] mv = '0;
    rv[7] = 1'b1; rv[33] = 1'b1; rv[34] = 1'b1; rv[80] = 1'b1; rv[99] = 1'b1;
    for (int i = 0; i < N; i++) mv[i] = (i % 4 == 3);
    runEnc(rv, mv, 1'b1, "busy R8");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testWrap();
    testExtraOnes();
    testFewOnes();
    testBusyEnc();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule